// File: doc/BRIEF.md
# Streaming Accumulator Stage with Backpressure

This block sits between an upstream data driver and a downstream output FIFO. Each cycle, the driver may present a data word together with an enable. When the stage takes the word, it adds it to a running sum in a single clock. On the following cycle it raises a done flag to mark the new sum as valid. A cycle with no valid input produces no valid output, so done works as a per-cycle valid that follows the input enable. It is not a one-shot completion flag that software polls.

The downstream FIFO drives a stop input while it is full. While stop is high, the stage refuses new input: enable is ignored, the sum is held and done stays low. The stage also passes stop straight back to the driver as a stall output, so the driver holds its data. The sum is unsigned and wraps modulo two to the output width.

Top module: `acc_stage`

## Requirements
- R1: While rst_ni is low, and after its release until the first accepted word, sum_o is 0 and done_o is 0.
- R2: A word is accepted at a rising edge when en_i is 1 and stop_i is 0 there. After that edge, sum_o equals the previous sum_o plus data_i, with data_i zero-extended to OUT_W bits.
- R3: done_o is 1 in the cycle after an accepted word and 0 in every other cycle, including every cycle that follows an edge where en_i was 0.
- R4: At an edge where stop_i is 1, en_i and data_i are ignored: sum_o keeps its value and done_o is 0 afterwards.
- R5: stall_o equals stop_i in the same cycle, with no register between them.
- R6: The sum wraps modulo 2^OUT_W. With OUT_W=16, 0xFFFF plus 1 gives 0x0000.
- R7: Words accepted on consecutive edges are each summed. Throughput is one word per cycle, and done_o stays 1 across the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Input word valid |
| data_i | input | IN_W | Input word, unsigned |
| stop_i | input | 1 | Downstream FIFO full |
| stall_o | output | 1 | Stall request to the upstream driver |
| sum_o | output | OUT_W | Running sum |
| done_o | output | 1 | sum_o holds a freshly updated result |

## Verification
The sum and the done flag are both due one rising edge after the edge at which en_i, data_i and stop_i are sampled. stall_o, by contrast, is due within the same cycle as stop_i. The bench drives inputs on the falling edge and checks stall_o shortly afterwards. It then advances its behavioural model at the next rising edge and compares sum_o and done_o one time unit after that edge. As a result, every check sees exactly one register stage between stimulus and result.

// File: rtl/acc_stage_pkg.sv
package acc_stage_pkg;
  typedef enum logic [1:0] {
    BEAT_IDLE = 2'd0,
    BEAT_TAKE = 2'd1,
    BEAT_HOLD = 2'd2
  } beat_e;
endpackage

// File: rtl/acc_admit.sv
module acc_admit
  import acc_stage_pkg::*;
(
  input  logic  en_i,
  input  logic  stop_i,
  output beat_e beat_o,
  output logic  stall_o
);
  always_comb begin
    if (stop_i)    beat_o = BEAT_HOLD;
    else if (en_i) beat_o = BEAT_TAKE;
    else           beat_o = BEAT_IDLE;
  end

  assign stall_o = stop_i;
endmodule

// File: rtl/acc_sum.sv
module acc_sum #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [IN_W-1:0]  data_i,
  output logic [OUT_W-1:0] sum_o
);
  logic [OUT_W-1:0] addend;
  logic [OUT_W-1:0] sum_q;

  generate
    if (IN_W >= OUT_W) begin : g_trunc
      assign addend = data_i[OUT_W-1:0];
    end else begin : g_zext
      assign addend = {{(OUT_W-IN_W){1'b0}}, data_i};
    end
  endgenerate

  // wraps naturally at OUT_W bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_q <= '0;
    else if (take_i) sum_q <= sum_q + addend;
  end

  assign sum_o = sum_q;

  a_r2_sum_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> sum_q == OUT_W'($past(sum_q) + $past(addend)));

  a_r4_sum_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(sum_q));
endmodule

// File: rtl/acc_flag.sv
module acc_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  output logic done_o
);
  logic done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= take_i;
  end

  assign done_o = done_q;
endmodule

// File: rtl/acc_stage.sv
module acc_stage
  import acc_stage_pkg::*;
#(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [IN_W-1:0]  data_i,
  input  logic             stop_i,
  output logic             stall_o,
  output logic [OUT_W-1:0] sum_o,
  output logic             done_o
);
  beat_e beat;
  logic  take;

  acc_admit u_admit (
    .en_i    (en_i),
    .stop_i  (stop_i),
    .beat_o  (beat),
    .stall_o (stall_o)
  );

  assign take = (beat == BEAT_TAKE);

  acc_sum #(.IN_W(IN_W), .OUT_W(OUT_W)) u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .data_i (data_i),
    .sum_o  (sum_o)
  );

  acc_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .done_o (done_o)
  );

  a_r3_done_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(en_i) && !$past(stop_i));

  a_r3_done_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !stop_i) |=> done_o);

  a_r4_stop_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !done_o && $stable(sum_o));

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> sum_o == '0 && !done_o);
endmodule

// File: tb/acc_stage_tb.sv
module acc_stage_tb;
  localparam int unsigned IN_W   = 8;
  localparam int unsigned OUT_W  = 16;
  localparam time         CLK_PER = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic [IN_W-1:0]  data = '0;
  logic             stop = 1'b0;
  logic             stall;
  logic [OUT_W-1:0] sum;
  logic             done;

  logic [OUT_W-1:0] exp_sum = '0;
  logic             exp_done = 1'b0;
  int               n_chk = 0;
  int               n_fail = 0;
  bit               finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  acc_stage #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .en_i    (en),
    .data_i  (data),
    .stop_i  (stop),
    .stall_o (stall),
    .sum_o   (sum),
    .done_o  (done)
  );

  task automatic chk(input string tag, input logic [OUT_W-1:0] act,
                     input logic [OUT_W-1:0] expv, input string what);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic step(input logic e, input logic [IN_W-1:0] d, input logic s,
                      input string tag);
    @(negedge clk);
    en = e; data = d; stop = s;
    #1;
    chk("R5", OUT_W'(stall), OUT_W'(s), "stall_o");
    if (e && !s) begin
      exp_sum  = exp_sum + OUT_W'(d);
      exp_done = 1'b1;
    end else begin
      exp_done = 1'b0;
    end
    @(posedge clk);
    #1;
    chk(tag, sum, exp_sum, "sum_o");
    chk(tag, OUT_W'(done), OUT_W'(exp_done), "done_o");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", sum, '0, "sum_o in reset");
    chk("R1", OUT_W'(done), '0, "done_o in reset");
    @(negedge clk);
    rst_n = 1'b1;
    // idle after reset
    for (int i = 0; i < 3; i++) step(1'b0, 8'hAA, 1'b0, "R1");
    // back-to-back burst
    for (int i = 0; i < 8; i++) step(1'b1, IN_W'(i * 17 + 3), 1'b0, "R7");
    // irregular validity
    for (int i = 0; i < 200; i++) begin
      logic e = 1'($urandom_range(0, 1));
      step(e, IN_W'($urandom), 1'b0, e ? "R2" : "R3");
    end
    // random stop with random enable
    for (int i = 0; i < 300; i++) begin
      logic e = 1'($urandom_range(0, 3) != 0);
      logic s = 1'($urandom_range(0, 2) == 0);
      step(e, IN_W'($urandom), s, s ? "R4" : (e ? "R2" : "R3"));
    end
    // long stop while enable held high
    for (int i = 0; i < 6; i++) step(1'b1, 8'hFF, 1'b1, "R4");
    // drive the sum past 2^OUT_W
    for (int i = 0; i < 300; i++) step(1'b1, 8'hFF, 1'b0, "R6");
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b0, "R3");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule